// File: doc/BRIEF.md
# Single-Step Trace Trap Controller

This block decides when a processor core must take its single-step trace trap. Status bit 4 of the processor word is the trace enable, and the trap goes through vector 14. The core gives the block three things: a strobe when an instruction word is fetched, a strobe when that instruction has finished, and a small decoded class for the instruction that finished. That class marks the two return-from-handler forms, the wait-for-interrupt instruction and the halt. The core also supplies the current trace enable bit and a set of flags for other traps of higher priority that are pending. From these inputs the block raises one trace request. The stacking sequence that follows the request, and the console logic that restarts a halted core, are handled elsewhere.

The block keeps an internal trace flag. This flag is captured from the trace enable at fetch time. An instruction therefore traps when it ran with tracing armed, even if it turned tracing off while it executed. An instruction that turns tracing on does not trap itself. The trap comes after the instruction that follows it. The two return forms differ. The trace-inhibiting return never traps at its own end. The plain return traps at once when the status word it restores has the trace bit set. A trace that collides with a higher-priority trap is put off to the next instruction boundary. A trace that becomes due at a halt is held until the core runs again.

Top module: `trace_trap_ctl`

## Requirements
- R1: While reset is active, and in the first cycle after reset, `trace_req` is low and no trace is armed, deferred or held.
- R2: On a clock edge where `fetch_stb` is 1, the internal trace flag takes the value of `t_bit`. The flag clears at an edge where `done_stb` is 1 and `fetch_stb` is 0. When an instruction fetched with the flag armed completes as a plain class (code 0), with no higher-priority trap and `halted` low, `trace_req` is high in the cycle after the `done_stb` edge.
- R3: An instruction fetched with `t_bit` low does not cause a trace request, even if `t_bit` is high when it completes.
- R4: An instruction fetched with `t_bit` high still traps when `t_bit` is low at its completion.
- R5: Class code 2 (return, trace-inhibiting) never raises a request from its own trace flag. The next instruction, if fetched with `t_bit` high, traps at its own completion.
- R6: Class code 1 (return, trace-permitting) traps at its completion if its flag was armed or if `t_bit` is high at completion.
- R7: Class code 3 (wait) traps on its `done_stb`, which marks entry into the wait state. The request does not wait for an interrupt.
- R8: If any bit of `hipri_pend` is set at a `done_stb` edge, no request is raised at that edge. Any trace that was due stays deferred. It is raised at the next `done_stb` edge that has no higher-priority trap, whatever the class or `t_bit` at that edge.
- R9: A trace that becomes due at the completion of class code 4 (halt), or while `halted` is high, is held. It is released as a request in the cycle after the edge where `halted` is first seen low after being high. `trace_req` never rises while `halted` was high at the previous edge.
- R10: In the default level mode, `trace_req` stays high until an edge with `trace_ack` high. A new request at that same edge wins over the acknowledge. Class codes 5 to 7 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_stb | input | 1 | Instruction word fetched this cycle |
| done_stb | input | 1 | Instruction completed this cycle |
| t_bit | input | 1 | Current trace enable, status bit 4 |
| instr_cls | input | CLS_W | Class of the completing instruction: 0 plain, 1 return, 2 return without trace, 3 wait, 4 halt |
| hipri_pend | input | NUM_HIPRI | Higher-priority trap pending flags, one per source |
| halted | input | 1 | Core is halted |
| trace_ack | input | 1 | Trap sequencer accepted the trace request |
| trace_req | output | 1 | Trace trap request through vector 14 |

## Verification
The main function is tested with short directed programs. One covers the instruction that arms tracing as opposed to the one it traces. One disarms tracing during the traced instruction. Each return form is run with tracing enabled, one after another, so that a one-instruction delay cannot be mistaken for an immediate trap. Further programs collide the trace with a higher-priority trap, and halt and then resume. Long constrained-random runs then overlap fetch and completion in the same cycle, use the unused class codes, and mix acknowledges with new requests and halt episodes. This shows whether deferral, holding and acknowledge ordering stay consistent with the requirements when these events coincide.

// File: rtl/trace_trap_pkg.sv
package trace_trap_pkg;

   typedef enum logic [2:0] {
      CLS_PLAIN = 3'd0,
      CLS_RET   = 3'd1,
      CLS_RETNT = 3'd2,
      CLS_WAIT  = 3'd3,
      CLS_HALT  = 3'd4
   } instr_cls_e;

   // Unknown or unused codes fall back to a plain instruction.
   function automatic instr_cls_e decode_cls(input logic [2:0] raw, input logic upper_set);
      instr_cls_e res;
      if (upper_set) begin
         res = CLS_PLAIN;
      end else begin
         unique case (raw)
            3'd1:    res = CLS_RET;
            3'd2:    res = CLS_RETNT;
            3'd3:    res = CLS_WAIT;
            3'd4:    res = CLS_HALT;
            default: res = CLS_PLAIN;
         endcase
      end
      return res;
   endfunction

endpackage

// File: rtl/tt_trace_flag.sv
module tt_trace_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic fetch_stb,
   input  logic done_stb,
   input  logic t_bit,
   output logic flag_q
);

   logic flag_d;

   always_comb begin
      flag_d = flag_q;
      if (fetch_stb)     flag_d = t_bit;
      else if (done_stb) flag_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   // R2
   flag_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_stb && !done_stb) |=> $stable(flag_q));

endmodule

// File: rtl/tt_boundary.sv
module tt_boundary
   import trace_trap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done_stb,
   input  instr_cls_e cls,
   input  logic       flag_q,
   input  logic       t_bit,
   input  logic       hipri_any,
   output logic       fire,
   output logic       pend_q
);

   logic own_due;
   logic due;
   logic pend_d;

   always_comb begin
      unique case (cls)
         CLS_RETNT: own_due = 1'b0;
         CLS_RET:   own_due = flag_q | t_bit;
         default:   own_due = flag_q;
      endcase
   end

   assign due = pend_q | own_due;

   always_comb begin
      fire   = 1'b0;
      pend_d = pend_q;
      if (done_stb) begin
         if (hipri_any) begin
            pend_d = due;
         end else begin
            fire   = due;
            pend_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
   end

   // R8
   pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !done_stb) |=> pend_q);

endmodule

// File: rtl/tt_issue.sv
module tt_issue #(
   parameter bit REQ_PULSE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic halt_cls,
   input  logic halted,
   input  logic halt_fall,
   input  logic trace_ack,
   output logic trace_req,
   output logic hold_q
);

   logic to_hold;
   logic release_now;
   logic set_req;
   logic hold_d;

   assign to_hold     = fire & (halt_cls | halted);
   assign release_now = hold_q & halt_fall;
   assign set_req     = (fire & ~to_hold) | release_now;

   always_comb begin
      hold_d = hold_q;
      if (to_hold)          hold_d = 1'b1;
      else if (release_now) hold_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= hold_d;
   end

   generate
      if (REQ_PULSE) begin : g_pulse
         logic req_q;
         always_ff @(posedge clk) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= set_req;
         end
         assign trace_req = req_q;
         logic ack_unused;
         assign ack_unused = trace_ack;
      end else begin : g_level
         logic req_q;
         always_ff @(posedge clk) begin
            if (!rst_n)         req_q <= 1'b0;
            else if (set_req)   req_q <= 1'b1;
            else if (trace_ack) req_q <= 1'b0;
         end
         assign trace_req = req_q;

         // R10
         ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(trace_req) |-> $past(trace_ack));
      end
   endgenerate

   // R9
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trace_req) |-> !$past(halted));

endmodule

// File: rtl/trace_trap_ctl.sv
module trace_trap_ctl
   import trace_trap_pkg::*;
#(
   parameter int unsigned CLS_W     = 3,
   parameter int unsigned NUM_HIPRI = 3,
   parameter bit          REQ_PULSE = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fetch_stb,
   input  logic                 done_stb,
   input  logic                 t_bit,
   input  logic [CLS_W-1:0]     instr_cls,
   input  logic [NUM_HIPRI-1:0] hipri_pend,
   input  logic                 halted,
   input  logic                 trace_ack,
   output logic                 trace_req
);

   localparam int unsigned CODE_W = 3;

   generate
      if (CLS_W < CODE_W) begin : g_bad_cls_w
         $error("trace_trap_ctl: CLS_W must be at least 3");
      end
      if (NUM_HIPRI < 1) begin : g_bad_hipri
         $error("trace_trap_ctl: NUM_HIPRI must be at least 1");
      end
   endgenerate

   logic       upper_set;
   instr_cls_e cls;
   logic       hipri_any;
   logic       halted_q;
   logic       halt_fall;
   logic       flag_q;
   logic       fire;
   logic       pend_q;
   logic       hold_q;

   generate
      if (CLS_W > CODE_W) begin : g_wide_cls
         assign upper_set = |instr_cls[CLS_W-1:CODE_W];
      end else begin : g_exact_cls
         assign upper_set = 1'b0;
      end
   endgenerate

   assign cls       = decode_cls(instr_cls[CODE_W-1:0], upper_set);
   assign hipri_any = |hipri_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) halted_q <= 1'b0;
      else        halted_q <= halted;
   end

   assign halt_fall = halted_q & ~halted;

   tt_trace_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .fetch_stb (fetch_stb),
      .done_stb  (done_stb),
      .t_bit     (t_bit),
      .flag_q    (flag_q)
   );

   tt_boundary u_bnd (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_stb  (done_stb),
      .cls       (cls),
      .flag_q    (flag_q),
      .t_bit     (t_bit),
      .hipri_any (hipri_any),
      .fire      (fire),
      .pend_q    (pend_q)
   );

   tt_issue #(
      .REQ_PULSE (REQ_PULSE)
   ) u_issue (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .halt_cls   (cls == CLS_HALT),
      .halted     (halted),
      .halt_fall  (halt_fall),
      .trace_ack  (trace_ack),
      .trace_req  (trace_req),
      .hold_q     (hold_q)
   );

   // R8
   hipri_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_stb && hipri_any && !halt_fall) |=> !$rose(trace_req));

   // R9
   hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && halted) |=> !$rose(trace_req));

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!trace_req && !pend_q && !hold_q && !flag_q));

endmodule

// File: tb/trace_trap_ctl_bench.sv
`timescale 1ns/1ps
module trace_trap_ctl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fetch_stb = 1'b0;
   logic       done_stb = 1'b0;
   logic       t_bit = 1'b0;
   logic [2:0] instr_cls = 3'd0;
   logic [2:0] hipri_pend = 3'd0;
   logic       halted = 1'b0;
   logic       trace_ack = 1'b0;
   wire        trace_req;

   int n_run  = 0;
   int n_fail = 0;

   bit m_flag, m_pend, m_hold, m_req, m_hq;

   always #4 clk = ~clk;

   trace_trap_ctl u_trace_trap_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .fetch_stb  (fetch_stb),
      .done_stb   (done_stb),
      .t_bit      (t_bit),
      .instr_cls  (instr_cls),
      .hipri_pend (hipri_pend),
      .halted     (halted),
      .trace_ack  (trace_ack),
      .trace_req  (trace_req)
   );

   // Trace due from the completing instruction's own flag (R3..R7).
   function automatic bit own_due(input logic [2:0] c, input bit flag, input bit t);
      if (c == 3'd2)      return 1'b0;
      else if (c == 3'd1) return flag | t;
      else                return flag;
   endfunction

   task automatic model_step();
      bit hh, fall, fire, want, tohold, rel, set;
      hh   = |hipri_pend;
      fall = m_hq && !halted;
      fire = 1'b0;
      if (done_stb) begin
         want = m_pend | own_due(instr_cls, m_flag, t_bit);
         if (hh) m_pend = want;
         else begin
            fire   = want;
            m_pend = 1'b0;
         end
      end
      tohold = fire && (instr_cls == 3'd4 || halted);
      rel    = m_hold && fall;
      set    = (fire && !tohold) || rel;
      if (tohold)   m_hold = 1'b1;
      else if (rel) m_hold = 1'b0;
      if (set)            m_req = 1'b1;
      else if (trace_ack) m_req = 1'b0;
      if (fetch_stb)     m_flag = t_bit;
      else if (done_stb) m_flag = 1'b0;
      m_hq = halted;
   endtask

   task automatic check(input string tag, input bit exp);
      n_run++;
      if (trace_req !== exp) begin
         n_fail++;
         $display("FAIL %s: trace_req=%b expected %b", tag, trace_req, exp);
      end
   endtask

   task automatic step(input bit f, input bit d, input bit t, input logic [2:0] c,
                       input logic [2:0] h, input bit hl, input bit ak, input string tag);
      fetch_stb  = f;
      done_stb   = d;
      t_bit      = t;
      instr_cls  = c;
      hipri_pend = h;
      halted     = hl;
      trace_ack  = ak;
      model_step();
      @(negedge clk);
      check(tag, m_req);
   endtask

   task automatic idle(input bit t);
      step(1'b0, 1'b0, t, 3'd0, 3'd0, 1'b0, 1'b0, "idle");
   endtask

   task automatic ack_now(input string tag);
      step(1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1, tag);
      check(tag, 1'b0);
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0014));
      repeat (3) @(negedge clk);
      check("R1", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 1'b0);

      // R3: the arming instruction itself does not trap
      step(1, 0, 0, 3'd0, 0, 0, 0, "R3");
      step(0, 1, 1, 3'd0, 0, 0, 0, "R3");
      check("R3", 1'b0);
      // R2: the next instruction traps after completing
      step(1, 0, 1, 3'd0, 0, 0, 0, "R2");
      check("R2", 1'b0);
      step(0, 1, 1, 3'd0, 0, 0, 0, "R2");
      check("R2", 1'b1);
      idle(1);
      check("R10", 1'b1);
      ack_now("R10");

      // R4: traced instruction clears T, still traps
      step(1, 0, 1, 3'd0, 0, 0, 0, "R4");
      step(0, 1, 0, 3'd0, 0, 0, 0, "R4");
      check("R4", 1'b1);
      ack_now("R4");

      // R5: trace-inhibiting return, then the following instruction traps
      step(1, 0, 1, 3'd0, 0, 0, 0, "R5");
      step(0, 1, 1, 3'd2, 0, 0, 0, "R5");
      check("R5", 1'b0);
      step(1, 0, 1, 3'd0, 0, 0, 0, "R5");
      step(0, 1, 1, 3'd0, 0, 0, 0, "R5");
      check("R5", 1'b1);
      ack_now("R5");

      // R6: plain return restoring T traps at once
      step(1, 0, 0, 3'd0, 0, 0, 0, "R6");
      step(0, 1, 1, 3'd1, 0, 0, 0, "R6");
      check("R6", 1'b1);
      ack_now("R6");

      // R7: wait traps on entry
      step(1, 0, 1, 3'd0, 0, 0, 0, "R7");
      step(0, 1, 1, 3'd3, 0, 0, 0, "R7");
      check("R7", 1'b1);
      ack_now("R7");

      // R8: deferred behind a higher-priority trap
      step(1, 0, 1, 3'd0, 0, 0, 0, "R8");
      step(0, 1, 1, 3'd0, 3'b010, 0, 0, "R8");
      check("R8", 1'b0);
      step(1, 0, 0, 3'd0, 0, 0, 0, "R8");
      step(0, 1, 0, 3'd2, 0, 0, 0, "R8");
      check("R8", 1'b1);
      ack_now("R8");

      // R9: held across a halt
      step(1, 0, 1, 3'd0, 0, 0, 0, "R9");
      step(0, 1, 1, 3'd4, 0, 0, 0, "R9");
      check("R9", 1'b0);
      for (int i = 0; i < 4; i++) begin
         step(0, 0, 1, 3'd0, 0, 1, 0, "R9");
         check("R9", 1'b0);
      end
      step(0, 0, 1, 3'd0, 0, 0, 0, "R9");
      check("R9", 1'b1);
      ack_now("R9");

      // R10: new request wins over acknowledge; unused code acts plain
      step(1, 0, 1, 3'd0, 0, 0, 0, "R10");
      step(0, 1, 1, 3'd0, 0, 0, 0, "R10");
      step(1, 0, 1, 3'd0, 0, 0, 0, "R10");
      step(0, 1, 1, 3'd6, 0, 0, 1, "R10");
      check("R10", 1'b1);
      ack_now("R10");

      // R2: constrained random mix
      for (int i = 0; i < 4000; i++) begin
         bit f, d, t, hl, ak;
         logic [2:0] c, h;
         f  = ($urandom % 4) == 0;
         d  = ($urandom % 3) == 0;
         t  = ($urandom % 3) != 0;
         c  = 3'($urandom % 8);
         h  = (($urandom % 6) == 0) ? 3'($urandom % 8) : 3'd0;
         hl = (($urandom % 10) == 0) ? ~halted : halted;
         ak = ($urandom % 4) == 0;
         step(f, d, t, c, h, hl, ak, "R2");
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule